// File: doc/BRIEF.md
# Maskable Write-One-Clear Interrupt Unit

This unit gathers eight event inputs from a serial bus controller into one status word and raises a single interrupt line. Six of the inputs report one-off happenings (packet finished, whole batch finished, transmit queue overrun, receive queue underrun, missing acknowledge, lost arbitration). The unit captures each of them in a sticky bit that software clears by writing a one to it. The remaining two inputs are transmit and receive data requests. These are live levels, and the status word only reflects them.

An enable mask selects which status bits drive the interrupt. For the controller variant that reports completion through a separate word, a done flag mirrors the interrupt line and has its own write-one-clear bit. Software reaches all of this through a flat register port: a 2-bit address, a write strobe, a 32-bit write word and a combinational read word. Address 0 is the status word, address 1 the mask, address 2 the done word and address 3 is unmapped.

Top module: `irq_collect_unit`

## Requirements
- R1: After reset the status word, mask, done flag and `irq_o` are all zero.
- R2: Status bits 7 (packet finished), 6 (batch finished), 5 (transmit overrun), 4 (receive underrun), 3 (no acknowledge) and 2 (arbitration lost) are sticky. They are set the clock after a one-cycle event and stay set after the event ends.
- R3: Status bit 1 (transmit data request) and bit 0 (receive data request) show their input level delayed by one clock, and writes to the status word do not change them.
- R4: A write to address 0 clears every sticky bit whose write-word bit is 1 and leaves the others alone. Writing 0xFF clears every sticky bit.
- R5: When an event and a clear of the same sticky bit fall in one cycle, the bit remains set.
- R6: The mask lives at address 1 in bits 7:0 and reads back what was written. Bits 31:8 read as zero.
- R7: `irq_o` is a register holding the OR of status AND mask from the previous cycle.
- R8: With a mask of zero, `irq_o` stays low whatever the status.
- R9: With `variant_i` high, the done flag (bit 30 at address 2) is set on the clock after `irq_o` is seen high. It stays set until a write to address 2 with bit 30 at 1 arrives while `irq_o` is low. Other bits of that write have no effect.
- R10: With `variant_i` low, the done flag is held at zero.
- R11: Address 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event inputs, one per status bit |
| variant_i | input | 1 | Enables the mirrored done flag |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word for `reg_addr` |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The bench sweeps all 64 sticky status patterns against all 256 mask values. A gating error, such as using OR where AND belongs or leaving out a bit, would raise the interrupt for an empty intersection or miss a live one. It pulses an event on the same clock that clears that bit. A design where the clear wins would lose the event. It writes 0xFF while the data-request levels are held high, which catches a design that lets writes reach the level bits. The done-flag sequence clears bit 30 while the interrupt is still high, and it also writes every other bit. This exposes a flag that drops early, ignores the variant input or decodes the wrong bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int EVT_COUNT   = 8;
    localparam int WORD_W      = 32;
    localparam int SEL_W       = 2;
    localparam int DONE_POS    = 30;
    localparam logic [EVT_COUNT-1:0] LEVEL_SRC = 8'h03;

    // status bit positions
    localparam int EV_PKT_DONE   = 7;
    localparam int EV_BATCH_DONE = 6;
    localparam int EV_TX_OVER    = 5;
    localparam int EV_RX_UNDER   = 4;
    localparam int EV_NO_ACK     = 3;
    localparam int EV_ARB_LOST   = 2;
    localparam int EV_TX_REQ     = 1;
    localparam int EV_RX_REQ     = 0;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_DONE   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic stat_clr;
        logic mask_wr;
        logic done_clr;
    } wr_req_t;

    function automatic wr_req_t decode_write(input logic we, input reg_sel_e sel,
                                             input logic done_bit);
        wr_req_t r;
        r.stat_clr = we && (sel == SEL_STATUS);
        r.mask_wr  = we && (sel == SEL_MASK);
        r.done_clr = we && (sel == SEL_DONE) && done_bit;
        return r;
    endfunction

endpackage

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
    parameter int N = 8,
    parameter logic [N-1:0] LEVEL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);

    logic [N-1:0] stat_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (LEVEL_MASK[i]) begin : g_level
            always_ff @(posedge clk) begin
                if (rst) stat_q[i] <= 1'b0;
                else     stat_q[i] <= evt_i[i];
            end

            AST_LEVEL_IGNORES_CLEAR: assert property (@(posedge clk) disable iff (rst)
                clr_i[i] |=> stat_q[i] == $past(evt_i[i])); // R3
        end else begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst) stat_q[i] <= 1'b0;
                else     stat_q[i] <= (stat_q[i] & ~clr_i[i]) | evt_i[i];
            end

            AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
                evt_i[i] |=> stat_q[i]); // R5
            AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
                (clr_i[i] && !evt_i[i]) |=> !stat_q[i]); // R4
            AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
                (stat_q[i] && !clr_i[i]) |=> stat_q[i]); // R2
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (wr_i) q <= d_i;
    end

    assign q_o = q;

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> q_o == $past(d_i)); // R6
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(q_o)); // R11

endmodule

// File: rtl/irqc_done_flag.sv
module irqc_done_flag (
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    input  logic irq_i,
    input  logic clr_i,
    output logic done_o
);

    logic done_q;

    always_ff @(posedge clk) begin
        if (rst)            done_q <= 1'b0;
        else if (!enable_i) done_q <= 1'b0;
        else                done_q <= (done_q & ~clr_i) | irq_i;
    end

    assign done_o = done_q;

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (enable_i && irq_i) |=> done_o); // R9
    AST_DONE_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !done_o); // R10

endmodule

// File: rtl/irq_collect_unit.sv
module irq_collect_unit
    import irqc_pkg::*;
#(
    parameter int N_EVT  = EVT_COUNT,
    parameter int DATA_W = WORD_W,
    parameter int DONE_B = DONE_POS,
    parameter logic [N_EVT-1:0] LEVEL_MASK = LEVEL_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              variant_i,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    localparam int PAD_W = DATA_W - N_EVT;

    reg_sel_e         sel;
    wr_req_t          req;
    logic [N_EVT-1:0] stat;
    logic [N_EVT-1:0] mask;
    logic [N_EVT-1:0] clr_vec;
    logic             done;
    logic             irq_q;
    logic             unused_wdata_bits;

    assign sel     = reg_sel_e'(reg_addr);
    assign req     = decode_write(reg_we, sel, reg_wdata[DONE_B]);
    assign clr_vec = req.stat_clr ? reg_wdata[N_EVT-1:0] : '0;
    assign unused_wdata_bits = ^{reg_wdata[DATA_W-1:DONE_B+1], reg_wdata[DONE_B-1:N_EVT]};

    irqc_status_bank #(.N(N_EVT), .LEVEL_MASK(LEVEL_MASK)) u_status (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_i),
        .clr_i  (clr_vec),
        .stat_o (stat)
    );

    irqc_mask_reg #(.W(N_EVT)) u_mask (
        .clk  (clk),
        .rst  (rst),
        .wr_i (req.mask_wr),
        .d_i  (reg_wdata[N_EVT-1:0]),
        .q_o  (mask)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(stat & mask);
    end

    assign irq_o = irq_q;

    irqc_done_flag u_done (
        .clk      (clk),
        .rst      (rst),
        .enable_i (variant_i),
        .irq_i    (irq_q),
        .clr_i    (req.done_clr),
        .done_o   (done)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = {{PAD_W{1'b0}}, stat};
            SEL_MASK:   reg_rdata = {{PAD_W{1'b0}}, mask};
            SEL_DONE:   reg_rdata = DATA_W'(done) << DONE_B;
            default:    reg_rdata = '0;
        endcase
    end

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_o == |($past(stat & mask))); // R7
    AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |=> !irq_o); // R8
    AST_UNMAPPED_STATUS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel == SEL_NONE && evt_i == '0) |=> (stat & ~LEVEL_MASK) == ($past(stat) & ~LEVEL_MASK)); // R11

endmodule

// File: tb/irq_collect_unit_bench.sv
module irq_collect_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  evt_i;
    logic        variant_i;
    logic [1:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    irq_collect_unit u_irq_collect_unit (
        .clk(clk), .rst(rst), .evt_i(evt_i), .variant_i(variant_i),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [7:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; evt_i = '0; variant_i = 1'b0;
        reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); check(v, 32'h0, "R1 status");
        rd(2'd1, v); check(v, 32'h0, "R1 mask");
        rd(2'd2, v); check(v, 32'h0, "R1 done");
        check({31'b0, irq_o}, 32'h0, "R1 irq");

        // R2 / R4 per sticky bit
        for (int i = 2; i < 8; i++) begin
            pulse(8'(1 << i));
            @(negedge clk);
            rd(2'd0, v); check(v, 32'(1 << i), "R2 sticky set");
            wr(2'd0, 32'h0000_00FF & ~32'(1 << i));
            rd(2'd0, v); check(v, 32'(1 << i), "R4 other clears keep bit");
            wr(2'd0, 32'(1 << i));
            rd(2'd0, v); check(v, 32'h0, "R4 own clear");
        end

        // R5 event and clear in one cycle
        for (int i = 2; i < 8; i++) begin
            @(negedge clk);
            evt_i = 8'(1 << i); reg_addr = 2'd0; reg_we = 1'b1; reg_wdata = 32'(1 << i);
            @(negedge clk);
            evt_i = '0; reg_we = 1'b0; reg_wdata = '0;
            rd(2'd0, v); check(v, 32'(1 << i), "R5 event wins");
            wr(2'd0, 32'hFF);
        end

        // R3 level bits
        @(negedge clk); evt_i = 8'h03;
        @(negedge clk);
        rd(2'd0, v); check(v, 32'h03, "R3 level high");
        reg_addr = 2'd0; reg_we = 1'b1; reg_wdata = 32'hFF;
        @(negedge clk); reg_we = 1'b0;
        rd(2'd0, v); check(v, 32'h03, "R3 write ignored");
        evt_i = 8'h01;
        @(negedge clk);
        rd(2'd0, v); check(v, 32'h01, "R3 level follows");
        evt_i = 8'h00;
        @(negedge clk);
        rd(2'd0, v); check(v, 32'h00, "R3 level low");

        // R6 mask readback
        wr(2'd1, 32'hFFFF_FFA5);
        rd(2'd1, v); check(v, 32'hA5, "R6 mask readback");

        // R7 / R8 sweep of sticky pattern x mask
        for (int s = 0; s < 64; s++) begin
            wr(2'd0, 32'hFF);
            if (s != 0) pulse(8'(s << 2));
            for (int m = 0; m < 256; m++) begin
                wr(2'd1, 32'(m));
                @(negedge clk);
                check({31'b0, irq_o}, {31'b0, |(8'(s << 2) & 8'(m))},
                      (m == 0) ? "R8 mask zero" : "R7 irq gating");
            end
        end
        wr(2'd0, 32'hFF);

        // R9 done flag in variant mode
        variant_i = 1'b1;
        wr(2'd1, 32'h80);
        pulse(8'h80);
        @(negedge clk); @(negedge clk);
        rd(2'd2, v); check(v, 32'h4000_0000, "R9 done set");
        wr(2'd2, 32'h4000_0000);
        rd(2'd2, v); check(v, 32'h4000_0000, "R9 set wins over clear");
        wr(2'd0, 32'h80);
        @(negedge clk); @(negedge clk);
        check({31'b0, irq_o}, 32'h0, "R9 irq dropped");
        rd(2'd2, v); check(v, 32'h4000_0000, "R9 done held");
        wr(2'd2, 32'hBFFF_FFFF);
        rd(2'd2, v); check(v, 32'h4000_0000, "R9 other bits ignored");
        wr(2'd2, 32'h4000_0000);
        rd(2'd2, v); check(v, 32'h0, "R9 done cleared");

        // R10 no done outside variant mode
        variant_i = 1'b0;
        pulse(8'h80);
        repeat (3) @(negedge clk);
        check({31'b0, irq_o}, 32'h1, "R10 irq high");
        rd(2'd2, v); check(v, 32'h0, "R10 done zero");

        // R11 unmapped address
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); check(v, 32'h0, "R11 read zero");
        rd(2'd0, v); check(v, 32'h80, "R11 status untouched");
        rd(2'd1, v); check(v, 32'h80, "R11 mask untouched");

        finish_run();
    end

endmodule